// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This block is the receive-side DMA engine of an Ethernet MAC. Frame bytes arrive one per cycle on a byte stream and are stored into fixed-size receive buffers. Each buffer is described by a two-word descriptor. The first word holds the buffer address, with ownership and wrap flags in its two lowest bits. The second word is a status word written by the engine. The engine walks the descriptor ring in order. A frame takes as many buffers as it needs, and it may run past the wrap point into the buffers at the start of the ring.

Descriptors are held inside the block. Software initialises and reclaims them through a small host port. Buffer bytes leave the block on a registered byte-write port toward the buffer memory. Address-filter results come in as inputs that are valid with the last byte of a frame, and they are recorded in the final descriptor of the frame.

If the engine needs a fresh buffer and the descriptor is still owned by software, no space is available. The engine then discards the rest of the frame, or the whole frame if nothing of it was stored yet, and raises a one-cycle no-buffer pulse.

Top module: `rx_ring_filler`

## Requirements
- R1: After reset every descriptor word reads zero, `buf_we`, `frame_done` and `no_buffer` are low, and the first frame is stored through descriptor 0.
- R2: Byte k of a stored frame is written on the buffer port one cycle after it is accepted. The address is the descriptor's address word with bits 1:0 cleared, plus (k mod 128).
- R3: When a buffer holds 128 bytes and the frame goes on, the engine sets bit 0 of that descriptor's address word. Its status word then has bit 14 set only if this is the frame's first buffer, with bit 15 clear and bits 11:0 zero. The next byte goes to the next descriptor.
- R4: On the last byte of a frame, the engine sets bit 0 of the current descriptor's address word. Its status word gets bit 15 set, bits 11:0 set to the frame length in bytes, and bit 14 set when the frame started in this buffer.
- R5: Filter results appear only in the last descriptor of a frame: bit 31 is broadcast, bit 22 is the type match, and `flt_addr_hit[i]` goes to bit 26-i. Descriptors that are not last carry zero in bits 31:16 and 11:0.
- R6: After a descriptor whose address-word bit 1 is set, or after the last index of the ring, the next descriptor used is index 0. A frame may span that point.
- R7: If the descriptor at the engine's position has bit 0 set when a frame starts, nothing of the frame is written. `no_buffer` pulses one cycle after the first byte, and no descriptor changes.
- R8: If a frame needs a new buffer and that descriptor has bit 0 set, the rest of the frame is discarded and `no_buffer` pulses. Descriptors already filled keep their contents, and the next frame starts at the blocked descriptor once software releases it.
- R9: A host write with `host_sel`=0 replaces the address word of descriptor `host_idx` from the next cycle on. A host write with `host_sel`=1 is ignored. `host_rdata` shows the selected word of `host_idx` combinationally (0 = address word, 1 = status word).
- R10: `frame_done` pulses one cycle after the last byte of a stored frame, and the final descriptor can be read from that cycle on.
- R11: The length field saturates at 4095, so a frame that fills all 4096 bytes of the default ring reports 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | This byte ends the frame |
| flt_bcast | input | 1 | Broadcast frame, valid with the last byte |
| flt_type_hit | input | 1 | Type-ID match, valid with the last byte |
| flt_addr_hit | input | 4 | Specific-address matches, bit i for address register i+1 |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Word select: 0 address word, 1 status word |
| host_idx | input | IDX_W | Descriptor index for host access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected descriptor word |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte |
| frame_done | output | 1 | A frame was completely stored |
| no_buffer | output | 1 | A frame, or the rest of one, was discarded for lack of a free buffer |

## Verification
The assertions check on every cycle that the engine never writes a descriptor whose ownership bit is already set, that a descriptor that is not last is closed only after exactly a full buffer of bytes, that such a descriptor carries no length or filter bits, that the position returns to zero after a wrap-flagged descriptor, and that a blocked byte does not move the position. Other behaviour shows only in the bench scenarios: exact byte addresses and data, length values and saturation, frames crossing the wrap point, and what happens to the descriptors and to the next frames after a drop at the start of a frame or in its middle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W      = 32;
  localparam int LEN_W       = 12;
  localparam int HIT_N       = 4;
  // address word flags
  localparam int OWN_BIT     = 0;
  localparam int WRAP_BIT    = 1;
  // status word fields
  localparam int SOF_BIT     = 14;
  localparam int EOF_BIT     = 15;
  localparam int TYPE_BIT    = 22;
  localparam int HIT_TOP_BIT = 26;
  localparam int BCAST_BIT   = 31;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LEN_W-1:0]  len_t;

  typedef struct packed {
    logic             bcast;
    logic             type_hit;
    logic [HIT_N-1:0] addr_hit;
  } filt_t;

  // saturating length step
  function automatic len_t len_step(input len_t cur);
    return (&cur) ? cur : cur + 1'b1;
  endfunction

  // byte address inside the buffer named by an address word
  function automatic word_t buf_byte_addr(input word_t dw, input word_t off);
    return {dw[WORD_W-1:2], 2'b00} + off;
  endfunction
endpackage

// File: rtl/rxr_status_pack.sv
module rxr_status_pack
  import rxr_pkg::*;
(
  input  logic  first,
  input  logic  last,
  input  len_t  len,
  input  filt_t filt,
  output word_t stat
);
  logic [HIT_N-1:0] hit_field;

  // address register i+1 lands i places below the top hit bit
  for (genvar i = 0; i < HIT_N; i++) begin : g_hit
    assign hit_field[HIT_N-1-i] = filt.addr_hit[i];
  end

  always_comb begin
    stat = '0;
    stat[SOF_BIT] = first;
    if (last) begin
      stat[EOF_BIT]                  = 1'b1;
      stat[LEN_W-1:0]                = len;
      stat[BCAST_BIT]                = filt.bcast;
      stat[TYPE_BIT]                 = filt.type_hit;
      stat[HIT_TOP_BIT -: HIT_N]     = hit_field;
    end
  end
endmodule

// File: rtl/rxr_desc_store.sv
module rxr_desc_store
  import rxr_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  word_t            eng_stat,
  input  logic [IDX_W-1:0] rd_idx,
  output word_t            rd_word,
  input  logic             host_we,
  input  logic             host_sel,
  input  logic [IDX_W-1:0] host_idx,
  input  word_t            host_wdata,
  output word_t            host_rdata
);
  word_t addr_q [DEPTH];
  word_t stat_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        stat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (eng_we && eng_idx == IDX_W'(i)) begin
          addr_q[i][OWN_BIT] <= 1'b1;
          stat_q[i]          <= eng_stat;
        end else if (host_we && !host_sel && host_idx == IDX_W'(i)) begin
          addr_q[i] <= host_wdata;
        end
      end
    end
  end

  assign rd_word    = addr_q[rd_idx];
  assign host_rdata = host_sel ? stat_q[host_idx] : addr_q[host_idx];

  // R3 R4
  own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> !addr_q[eng_idx][OWN_BIT]);

  // R5
  mid_desc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && !eng_stat[EOF_BIT]) |->
      (eng_stat[LEN_W-1:0] == '0) && (eng_stat[BCAST_BIT:16] == '0));
endmodule

// File: rtl/rxr_fill_ctrl.sv
module rxr_fill_ctrl
  import rxr_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int BUF_BYTES = 128,
  parameter int IDX_W     = $clog2(DEPTH),
  parameter int OFF_W     = $clog2(BUF_BYTES)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  word_t            cur_word,
  output logic [IDX_W-1:0] ptr,
  output logic             ev_store,
  output logic             ev_blocked,
  output logic             eng_we,
  output logic             eng_first,
  output logic             eng_last,
  output len_t             eng_len,
  output logic             buf_we,
  output word_t            buf_addr,
  output logic [7:0]       buf_data,
  output logic             frame_done,
  output logic             no_buffer
);
  logic             busy_q, drop_q, first_q;
  logic [IDX_W-1:0] ptr_q;
  logic [OFF_W-1:0] off_q;
  len_t             len_q;
  logic             buf_we_q, done_q, nobuf_q;
  word_t            buf_addr_q;
  logic [7:0]       buf_data_q;

  logic used_now, wrap_now, at_buf_end, is_first, close;
  len_t len_now;

  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p,
                                                 input logic wrap);
    if (wrap || p == IDX_W'(DEPTH-1)) return '0;
    return p + 1'b1;
  endfunction

  assign used_now   = cur_word[OWN_BIT];
  assign wrap_now   = cur_word[WRAP_BIT];
  assign at_buf_end = (off_q == OFF_W'(BUF_BYTES-1));
  assign ev_blocked = in_valid && !drop_q && (off_q == '0) && used_now;
  assign ev_store   = in_valid && !drop_q && !ev_blocked;
  assign close      = ev_store && (in_last || at_buf_end);
  assign is_first   = busy_q ? first_q : 1'b1;
  assign len_now    = len_step(len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      drop_q     <= 1'b0;
      first_q    <= 1'b0;
      ptr_q      <= '0;
      off_q      <= '0;
      len_q      <= '0;
      buf_we_q   <= 1'b0;
      buf_addr_q <= '0;
      buf_data_q <= '0;
      done_q     <= 1'b0;
      nobuf_q    <= 1'b0;
    end else begin
      buf_we_q <= ev_store;
      done_q   <= ev_store && in_last;
      nobuf_q  <= ev_blocked;
      if (ev_store) begin
        buf_addr_q <= buf_byte_addr(cur_word, 32'(off_q));
        buf_data_q <= in_data;
      end
      if (ev_blocked) begin
        drop_q <= !in_last;
        busy_q <= 1'b0;
        len_q  <= '0;
      end else if (drop_q && in_valid && in_last) begin
        drop_q <= 1'b0;
      end else if (ev_store) begin
        busy_q  <= !in_last;
        len_q   <= in_last ? '0 : len_now;
        off_q   <= close ? '0 : off_q + 1'b1;
        first_q <= is_first && !close;
        if (close) ptr_q <= ring_next(ptr_q, wrap_now);
      end
    end
  end

  assign ptr        = ptr_q;
  assign eng_we     = close;
  assign eng_first  = is_first;
  assign eng_last   = in_last;
  assign eng_len    = len_now;
  assign buf_we     = buf_we_q;
  assign buf_addr   = buf_addr_q;
  assign buf_data   = buf_data_q;
  assign frame_done = done_q;
  assign no_buffer  = nobuf_q;

  // R6
  wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close && wrap_now) |=> (ptr_q == '0));

  // R7 R8
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blocked |=> (ptr_q == $past(ptr_q)) && !buf_we_q);
endmodule

// File: rtl/rx_ring_filler.sv
module rx_ring_filler
  import rxr_pkg::*;
#(
  parameter int  RING_DEPTH = 32,
  parameter int  BUF_BYTES  = 128,
  localparam int IDX_W      = $clog2(RING_DEPTH)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             flt_bcast,
  input  logic             flt_type_hit,
  input  logic [3:0]       flt_addr_hit,
  input  logic             host_we,
  input  logic             host_sel,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             buf_we,
  output logic [31:0]      buf_addr,
  output logic [7:0]       buf_data,
  output logic             frame_done,
  output logic             no_buffer
);
  localparam int OFF_W = $clog2(BUF_BYTES);

  logic [IDX_W-1:0] ptr;
  word_t            cur_word, eng_stat;
  logic             ev_store, ev_blocked, eng_we, eng_first, eng_last;
  len_t             eng_len;
  filt_t            filt;

  assign filt = '{bcast: flt_bcast, type_hit: flt_type_hit, addr_hit: flt_addr_hit};

  rxr_desc_store #(.DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .eng_we(eng_we), .eng_idx(ptr), .eng_stat(eng_stat),
    .rd_idx(ptr), .rd_word(cur_word),
    .host_we(host_we), .host_sel(host_sel), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  rxr_status_pack u_pack (
    .first(eng_first), .last(eng_last), .len(eng_len), .filt(filt), .stat(eng_stat)
  );

  rxr_fill_ctrl #(.DEPTH(RING_DEPTH), .BUF_BYTES(BUF_BYTES),
                  .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .cur_word(cur_word), .ptr(ptr),
    .ev_store(ev_store), .ev_blocked(ev_blocked),
    .eng_we(eng_we), .eng_first(eng_first), .eng_last(eng_last), .eng_len(eng_len),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .frame_done(frame_done), .no_buffer(no_buffer)
  );

  // bytes stored since the last descriptor closed, counted independently
  logic [OFF_W:0] fill_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                   fill_cnt <= '0;
    else if (eng_we || ev_blocked) fill_cnt <= '0;
    else if (ev_store)             fill_cnt <= fill_cnt + 1'b1;
  end

  // R3
  full_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && !eng_last) |-> (fill_cnt == (OFF_W+1)'(BUF_BYTES-1)));

  // R10
  done_only_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> buf_we && !no_buffer);
endmodule

// File: tb/tb_rx_ring_filler.sv
module tb_rx_ring_filler;
  localparam int DEPTH = 32;
  localparam int BUFB  = 128;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic flt_bcast = 0, flt_type_hit = 0;
  logic [3:0] flt_addr_hit = 0;
  logic host_we = 0, host_sel = 0;
  logic [4:0] host_idx = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic buf_we, frame_done, no_buffer;
  logic [31:0] buf_addr;
  logic [7:0] buf_data;

  int checks = 0, errors = 0;
  string tag = "R1";

  rx_ring_filler dut (.*);

  always #2 clk = ~clk;

  // reference model state
  logic [31:0] m_addr [DEPTH];
  logic [31:0] m_stat [DEPTH];
  int m_ptr, m_off, m_len;
  bit m_busy, m_first, m_drop;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(bit first, bit last, int len, logic [6:0] fl);
    logic [31:0] s = 0;
    if (first) s = s | 32'h4000;
    if (last) begin
      s = s | 32'h8000 | (32'(len) & 32'hFFF);
      if (fl[6]) s = s | 32'h8000_0000;
      if (fl[5]) s = s | (32'h1 << 22);
      for (int i = 0; i < 4; i++) if (fl[i]) s = s | (32'h1 << (26 - i));
    end
    return s;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_addr[i] = 0; m_stat[i] = 0; end
    m_ptr = 0; m_off = 0; m_len = 0; m_busy = 0; m_first = 0; m_drop = 0;
  endtask

  // one byte: drive at negedge, check outputs just after the next rising edge
  task automatic put_byte(input logic [7:0] d, input bit last, input logic [6:0] fl);
    bit ew = 0, ed = 0, en = 0;
    logic [31:0] ea = 0;
    if (m_drop) begin
      if (last) m_drop = 0;
    end else if (m_off == 0 && m_addr[m_ptr][0]) begin
      en = 1; m_drop = !last; m_busy = 0; m_len = 0;
    end else begin
      if (!m_busy) begin m_first = 1; m_len = 0; m_busy = 1; end
      ew = 1;
      ea = (m_addr[m_ptr] & 32'hFFFF_FFFC) + 32'(m_off);
      m_len = (m_len >= 4095) ? 4095 : m_len + 1;
      if (last || m_off == BUFB - 1) begin
        bit wr = m_addr[m_ptr][1];
        m_stat[m_ptr] = exp_status(m_first, last, m_len, fl);
        m_addr[m_ptr] = m_addr[m_ptr] | 1;
        m_ptr = (wr || m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
        m_off = 0; m_first = 0;
        if (last) begin ed = 1; m_busy = 0; end
      end else m_off++;
    end
    @(negedge clk);
    in_valid = 1; in_data = d; in_last = last;
    {flt_bcast, flt_type_hit, flt_addr_hit} = last ? {fl[6], fl[5], fl[3:0]} : 6'd0;
    @(posedge clk); #1;
    chk(buf_we == ew, {tag, " R2 buf_we"}, 32'(buf_we), 32'(ew));
    if (ew) chk(buf_addr == ea && buf_data == d, {tag, " R2 byte addr/data"},
                buf_addr, ea);
    chk(frame_done == ed, {tag, " R10 frame_done"}, 32'(frame_done), 32'(ed));
    chk(no_buffer == en, {tag, " R7 R8 no_buffer"}, 32'(no_buffer), 32'(en));
  endtask

  task automatic send_frame(input int len, input logic [6:0] fl);
    for (int k = 0; k < len; k++) put_byte(8'($urandom), k == len - 1, fl);
    @(negedge clk); in_valid = 0; in_last = 0;
  endtask

  task automatic host_write(input int idx, input bit sel, input logic [31:0] v);
    @(negedge clk);
    host_we = 1; host_sel = sel; host_idx = 5'(idx); host_wdata = v;
    @(negedge clk); host_we = 0;
    if (!sel) m_addr[idx] = v;
  endtask

  task automatic host_read(input int idx, input bit sel, output logic [31:0] v);
    @(negedge clk);
    host_sel = sel; host_idx = 5'(idx);
    #1 v = host_rdata;
  endtask

  task automatic check_ring(input string req);
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      host_read(i, 0, v); chk(v === m_addr[i], {req, " addr word"}, v, m_addr[i]);
      host_read(i, 1, v); chk(v === m_stat[i], {req, " status word"}, v, m_stat[i]);
    end
  endtask

  task automatic release_all();
    for (int i = 0; i < DEPTH; i++)
      if (m_addr[i][0]) host_write(i, 0, m_addr[i] & 32'hFFFF_FFFE);
  endtask

  task automatic configure(input int wrap_at);
    for (int i = 0; i < DEPTH; i++)
      host_write(i, 0, 32'h0001_0000 + 32'(i * BUFB) + ((i == wrap_at) ? 32'h2 : 32'h0));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  function automatic int ring_after(int p, int n);
    int q = p;
    for (int i = 0; i < n; i++) q = (m_addr[q][1] || q == DEPTH - 1) ? 0 : q + 1;
    return q;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int hold;
    void'($urandom(32'd4242));
    model_reset();
    do_reset();

    // R1 reset state
    tag = "R1";
    #1;
    chk(!buf_we && !frame_done && !no_buffer, "R1 outputs idle", 32'({buf_we, frame_done, no_buffer}), 0);
    host_read(0, 0, v);  chk(v == 0, "R1 desc0 addr zero", v, 0);
    host_read(31, 1, v); chk(v == 0, "R1 desc31 status zero", v, 0);

    // R9 host port: eight-entry ring, wrap flag on index 7
    tag = "R9";
    configure(7);
    host_read(5, 0, v); chk(v == m_addr[5], "R9 addr readback", v, m_addr[5]);
    host_read(7, 0, v); chk(v == m_addr[7], "R9 wrap readback", v, m_addr[7]);
    host_write(3, 1, 32'hFFFF_FFFF);
    host_read(3, 1, v); chk(v == 0, "R9 status write ignored", v, 0);

    // directed lengths: R1 first frame in desc 0, R3 full buffer, R4 end
    tag = "R4";  send_frame(1, 7'h40);   check_ring("R1 R4 one-byte frame"); release_all();
    tag = "R3";  send_frame(128, 7'h21); check_ring("R3 R4 exact buffer");   release_all();
    tag = "R3";  send_frame(129, 7'h0A); check_ring("R3 R5 buffer plus one"); release_all();
    tag = "R5";  send_frame(300, 7'h7F); check_ring("R5 three buffers");     release_all();

    // R6 random frames crossing the wrap point
    tag = "R6";
    for (int f = 0; f < 20; f++) begin
      send_frame($urandom_range(1, 700), 7'($urandom));
      check_ring("R6 random frame");
      release_all();
    end

    // R8 blocked in mid-frame
    tag = "R8";
    hold = ring_after(m_ptr, 2);
    host_write(hold, 0, m_addr[hold] | 1);
    send_frame(400, 7'h10);
    check_ring("R8 partial frame kept");
    // R7 blocked at frame start
    tag = "R7";
    send_frame(10, 7'h01);
    check_ring("R7 frame fully dropped");
    release_all();
    tag = "R8";
    send_frame(10, 7'h02);
    chk(m_stat[hold][15] == 1'b1, "R8 model resumes at blocked desc", 32'(m_stat[hold]), 32'h8000);
    check_ring("R8 resumes at blocked descriptor");
    release_all();

    // R11 length saturation over a full 32-entry ring, R6 end-of-array wrap
    tag = "R11";
    do_reset();
    configure(-1);
    send_frame(4096, 7'h40);
    host_read(31, 1, v);
    chk(v == (32'h8000_8000 | 32'd4095), "R11 saturated length", v, 32'h8000_8FFF);
    check_ring("R11 full ring");
    release_all();
    tag = "R6";
    send_frame(5, 7'h00);
    host_read(0, 1, v);
    chk(v == (32'hC000 | 32'd5), "R6 wrap after last index", v, 32'hC005);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule